// File: doc/BRIEF.md
# Card Write Busy Signalling Controller

This card-side block drives the busy indication on the DAT0 data line once a write data block has arrived intact. An upstream receiver reports each block whose CRC check succeeded. The controller counts how many received blocks still wait for the internal write engine, and it treats the write buffer as full when that count reaches its capacity. While the card is selected, a write is in progress and the buffer is full, the controller pulls DAT0 low. At all other times it leaves the line tri-stated. The write engine reports each finished block, and each report frees one slot.

Selection of the card is tracked separately from the write. A deselect event releases DAT0 at once, but the pending writes keep their place and still complete. A later select event drives the line low again only if the buffer is still full at that point. A status request returns a ready-for-data bit. The bit is 1 when the buffer can take another block. Status can be read at any time, including while the card is busy.

Top module: `wbsy_ctrl`

## Requirements
- R1: After reset the card is deselected with no pending blocks, `dat0_oe` is 0 and `stat_vld` is 0. Selecting the card in that state leaves `dat0_oe` at 0.
- R2: While selected, a `blk_ok` pulse that fills the buffer sets `dat0_oe` to 1 at the clock edge that samples it.
- R3: A `wr_done` pulse that takes the buffer below full clears `dat0_oe` at the clock edge that samples it.
- R4: `dat0_o` is always 0, so the line is either driven low (`dat0_oe`=1) or released (`dat0_oe`=0) and is never driven high.
- R5: A `stat_req` pulse gives a one-cycle `stat_vld` pulse at the next edge, and this also works while busy. With the buffer full, `stat_rdy` is 0. With a free slot, it is 1.
- R6: The ready flag is the inverse of buffer-full and changes at the edge that samples `wr_done`. A `stat_req` in the same cycle as `wr_done` therefore returns 0, and a request one cycle later returns 1.
- R7: `desel_evt` clears `dat0_oe` at its edge. Pending writes are not discarded.
- R8: `sel_evt` while the buffer is still full sets `dat0_oe` to 1 at its edge.
- R9: If the pending writes complete while the card is deselected, a later `sel_evt` leaves `dat0_oe` at 0.
- R10: A `blk_ok` that arrives while the buffer is full is dropped. A single `wr_done` then leaves the card ready.
- R11: With `BUF_BLOCKS`=2, busy appears only after the second accepted block and clears after the first completion.
- R12: `sel_evt` and `desel_evt` in the same cycle leave the selection unchanged.
- R13: A `wr_done` with no block pending is ignored, and the pending count does not wrap.
- R14: A `blk_ok` while the card is deselected is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_ok | input | 1 | Pulse: data block received with good CRC |
| wr_done | input | 1 | Pulse: internal write of one block finished |
| sel_evt | input | 1 | Pulse: select command addressed this card |
| desel_evt | input | 1 | Pulse: select command addressed another card |
| stat_req | input | 1 | Pulse: status command received |
| dat0_oe | output | 1 | DAT0 output enable (1 = drive busy) |
| dat0_o | output | 1 | DAT0 output level, constant 0 |
| stat_vld | output | 1 | Status reply strobe |
| stat_rdy | output | 1 | Ready-for-data bit of the status reply |

## Verification
A pending count that is off by one shows up at `dat0_oe` in one of two ways: busy rises on the wrong block, or it fails to fall on the completion that should free the buffer. Either error is visible on the edge that samples the event. If the selection flag is wrong, busy appears while deselected, or it fails to return on reselect, in the same cycle as the select event. A ready flag that is stale or inverted appears in the very next status reply. The bench therefore samples each output one edge after every stimulus.

// File: rtl/wbsy_pkg.sv
package wbsy_pkg;

  typedef enum logic [1:0] {
    LNK_IDLE_OFF = 2'd0,  // deselected, nothing pending
    LNK_IDLE_ON  = 2'd1,  // selected, nothing pending
    LNK_PROG_ON  = 2'd2,  // selected, writes pending
    LNK_PROG_OFF = 2'd3   // deselected, writes pending
  } link_state_e;

  function automatic link_state_e link_of(input logic sel, input logic prog);
    if (sel) return prog ? LNK_PROG_ON : LNK_IDLE_ON;
    else     return prog ? LNK_PROG_OFF : LNK_IDLE_OFF;
  endfunction

endpackage

// File: rtl/wbsy_fill.sv
module wbsy_fill #(
  parameter int BUF_BLOCKS = 1,
  localparam int CW = $clog2(BUF_BLOCKS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  output logic [CW-1:0] cnt_q,
  output logic          full_q,
  output logic          full_nx,
  output logic          prog_nx
);

  logic [CW-1:0] cnt_nx;
  logic          acc, rel;

  assign full_q = (cnt_q == CW'(BUF_BLOCKS));
  assign acc    = push && !full_q;
  assign rel    = pop && (cnt_q != '0);

  generate
    if (BUF_BLOCKS == 1) begin : g_flag
      always_comb begin
        cnt_nx = cnt_q;
        if (acc) cnt_nx = 1'b1;
        else if (rel) cnt_nx = 1'b0;
      end
    end else begin : g_count
      always_comb begin
        cnt_nx = cnt_q;
        case ({acc, rel})
          2'b10:   cnt_nx = cnt_q + 1'b1;
          2'b01:   cnt_nx = cnt_q - 1'b1;
          default: cnt_nx = cnt_q;
        endcase
      end
    end
  endgenerate

  assign full_nx = (cnt_nx == CW'(BUF_BLOCKS));
  assign prog_nx = (cnt_nx != '0);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nx;
  end

  a_r13_no_wrap: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(BUF_BLOCKS));
  a_r13_idle_pop: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && pop && !push) |=> cnt_q == '0);
  a_r10_full_push: assert property (@(posedge clk) disable iff (rst)
    (full_q && push && !pop) |=> full_q);

endmodule

// File: rtl/wbsy_link.sv
module wbsy_link
  import wbsy_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sel_evt,
  input  logic        desel_evt,
  input  logic        prog_nx,
  output logic        sel_nx,
  output link_state_e state_q
);

  logic sel_q;

  always_comb begin
    sel_nx = sel_q;
    if (sel_evt && !desel_evt)      sel_nx = 1'b1;
    else if (desel_evt && !sel_evt) sel_nx = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= 1'b0;
      state_q <= LNK_IDLE_OFF;
    end else begin
      sel_q   <= sel_nx;
      state_q <= link_of(sel_nx, prog_nx);
    end
  end

  a_r12_both_hold: assert property (@(posedge clk) disable iff (rst)
    (sel_evt && desel_evt) |=> sel_q == $past(sel_q));
  a_r7_desel_off: assert property (@(posedge clk) disable iff (rst)
    (desel_evt && !sel_evt) |=> (state_q == LNK_IDLE_OFF || state_q == LNK_PROG_OFF));

endmodule

// File: rtl/wbsy_stat.sv
module wbsy_stat (
  input  logic clk,
  input  logic rst,
  input  logic stat_req,
  input  logic rdy_q,
  output logic stat_vld,
  output logic stat_rdy
);

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_vld <= 1'b0;
      stat_rdy <= 1'b0;
    end else begin
      stat_vld <= stat_req;
      if (stat_req) stat_rdy <= rdy_q;
    end
  end

  a_r5_strobe: assert property (@(posedge clk) disable iff (rst)
    stat_req |=> stat_vld);
  a_r5_no_strobe: assert property (@(posedge clk) disable iff (rst)
    !stat_req |=> !stat_vld);

endmodule

// File: rtl/wbsy_ctrl.sv
module wbsy_ctrl
  import wbsy_pkg::*;
#(
  parameter int BUF_BLOCKS = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic blk_ok,
  input  logic wr_done,
  input  logic sel_evt,
  input  logic desel_evt,
  input  logic stat_req,
  output logic dat0_oe,
  output logic dat0_o,
  output logic stat_vld,
  output logic stat_rdy
);

  localparam int CW = $clog2(BUF_BLOCKS + 1);

  logic [CW-1:0] cnt_q;
  logic          full_q, full_nx, prog_nx, sel_nx;
  logic          rdy_q, oe_q;
  link_state_e   state_q;

  // Blocks are only taken while the card is selected.
  wbsy_fill #(.BUF_BLOCKS(BUF_BLOCKS)) fill_i (
    .clk(clk), .rst(rst),
    .push(blk_ok && (state_q == LNK_IDLE_ON || state_q == LNK_PROG_ON)),
    .pop(wr_done),
    .cnt_q(cnt_q), .full_q(full_q), .full_nx(full_nx), .prog_nx(prog_nx)
  );

  wbsy_link link_i (
    .clk(clk), .rst(rst),
    .sel_evt(sel_evt), .desel_evt(desel_evt),
    .prog_nx(prog_nx), .sel_nx(sel_nx), .state_q(state_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q  <= 1'b0;
      rdy_q <= 1'b1;
    end else begin
      oe_q  <= sel_nx && prog_nx && full_nx;
      rdy_q <= !full_nx;
    end
  end

  wbsy_stat stat_i (
    .clk(clk), .rst(rst), .stat_req(stat_req), .rdy_q(rdy_q),
    .stat_vld(stat_vld), .stat_rdy(stat_rdy)
  );

  assign dat0_oe = oe_q;
  assign dat0_o  = 1'b0;

  a_r2_busy_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(dat0_oe) |-> ($past(blk_ok) || $past(sel_evt)));
  a_r7_keep_write: assert property (@(posedge clk) disable iff (rst)
    (desel_evt && !blk_ok && !wr_done) |=> cnt_q == $past(cnt_q));
  a_r3_release: assert property (@(posedge clk) disable iff (rst)
    (full_q && wr_done) |=> !dat0_oe);
  a_r14_off_busy: assert property (@(posedge clk) disable iff (rst)
    (state_q == LNK_PROG_OFF || state_q == LNK_IDLE_OFF) |-> !dat0_oe);

  always_comb begin
    a_r4_low_only: assert (dat0_o == 1'b0);
  end

endmodule

// File: tb/wbsy_ctrl_tb.sv
module wbsy_ctrl_tb_top;

  logic clk = 1'b0;
  logic rst, blk_ok, wr_done, sel_evt, desel_evt, stat_req;
  logic oe1, o1, vld1, rdy1;
  logic oe2, o2, vld2, rdy2;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  wbsy_ctrl #(.BUF_BLOCKS(1)) dut_i (
    .clk(clk), .rst(rst), .blk_ok(blk_ok), .wr_done(wr_done),
    .sel_evt(sel_evt), .desel_evt(desel_evt), .stat_req(stat_req),
    .dat0_oe(oe1), .dat0_o(o1), .stat_vld(vld1), .stat_rdy(rdy1));

  wbsy_ctrl #(.BUF_BLOCKS(2)) dut2_i (
    .clk(clk), .rst(rst), .blk_ok(blk_ok), .wr_done(wr_done),
    .sel_evt(sel_evt), .desel_evt(desel_evt), .stat_req(stat_req),
    .dat0_oe(oe2), .dat0_o(o2), .stat_vld(vld2), .stat_rdy(rdy2));

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Inputs are set on a falling edge, sampled at the next rising edge, and
  // outputs are read on the falling edge after that.
  task automatic step(input logic b, input logic d, input logic s,
                      input logic ds, input logic q);
    blk_ok = b; wr_done = d; sel_evt = s; desel_evt = ds; stat_req = q;
    @(negedge clk);
    blk_ok = 0; wr_done = 0; sel_evt = 0; desel_evt = 0; stat_req = 0;
  endtask

  task automatic do_reset();
    rst = 1;
    blk_ok = 0; wr_done = 0; sel_evt = 0; desel_evt = 0; stat_req = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 oe after reset", oe1, 0);
    chk("R1 vld after reset", vld1, 0);
    step(0,0,1,0,0);
    chk("R1 select idle no busy", oe1, 0);
    step(0,0,0,0,1);
    chk("R5 strobe", vld1, 1);
    chk("R5 ready when empty", rdy1, 1);
    step(0,0,0,0,0);
    chk("R5 strobe one cycle", vld1, 0);
  endtask

  task automatic t_busy();
    do_reset();
    step(0,0,1,0,0);
    step(1,0,0,0,0);
    chk("R2 busy after block", oe1, 1);
    chk("R4 level low", o1, 0);
    chk("R11 one block not full", oe2, 0);
    step(0,0,0,0,1);
    chk("R5 strobe while busy", vld1, 1);
    chk("R5 not ready while busy", rdy1, 0);
    step(0,1,0,0,1);
    chk("R3 release on done", oe1, 0);
    chk("R6 same-cycle status old", rdy1, 0);
    step(0,0,0,0,1);
    chk("R6 next status ready", rdy1, 1);
  endtask

  task automatic t_desel();
    do_reset();
    step(0,0,1,0,0);
    step(1,0,0,0,0);
    step(0,0,0,1,0);
    chk("R7 deselect releases", oe1, 0);
    chk("R4 level low", o1, 0);
    step(0,0,1,0,0);
    chk("R8 reselect busy again", oe1, 1);
    step(0,1,0,0,0);
    chk("R3 release after reselect", oe1, 0);
  endtask

  task automatic t_done_off();
    do_reset();
    step(0,0,1,0,0);
    step(1,0,0,0,0);
    step(0,0,0,1,0);
    step(0,1,0,0,0);
    step(0,0,1,0,0);
    chk("R9 no busy after done while off", oe1, 0);
    step(0,0,0,0,1);
    chk("R9 ready after done while off", rdy1, 1);
  endtask

  task automatic t_drop();
    do_reset();
    step(0,0,1,0,0);
    step(1,0,0,0,0);
    step(1,0,0,0,0);
    chk("R10 still busy", oe1, 1);
    chk("R11 two blocks full", oe2, 1);
    step(0,1,0,0,0);
    chk("R10 one done frees", oe1, 0);
    chk("R11 one done frees", oe2, 0);
    step(0,0,0,0,1);
    chk("R10 ready after extra block dropped", rdy1, 1);
    chk("R11 ready with one pending", rdy2, 1);
  endtask

  task automatic t_both();
    do_reset();
    step(0,0,1,0,0);
    step(1,0,0,0,0);
    step(0,0,1,1,0);
    chk("R12 both keep selected", oe1, 1);
    do_reset();
    step(0,0,1,1,0);
    step(1,0,0,0,0);
    chk("R12 both keep deselected", oe1, 0);
  endtask

  task automatic t_underflow();
    do_reset();
    step(0,0,1,0,0);
    step(0,1,0,0,0);
    step(1,0,0,0,0);
    chk("R13 idle done ignored", oe2, 0);
    step(1,0,0,0,0);
    chk("R13 second block fills", oe2, 1);
  endtask

  task automatic t_off_block();
    do_reset();
    step(1,0,0,0,0);
    chk("R14 no busy when off", oe1, 0);
    step(0,0,1,0,0);
    chk("R14 block while off ignored", oe1, 0);
    step(0,0,0,0,1);
    chk("R14 still ready", rdy1, 1);
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        t_reset();
        t_busy();
        t_desel();
        t_done_off();
        t_drop();
        t_both();
        t_underflow();
        t_off_block();
      end
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule